// File: doc/BRIEF.md
# Run-Time Selectable Polynomial GF(2^8) Multiplier

This block multiplies two bytes as elements of GF(2^8), where the reduction polynomial is not fixed at design time but chosen by a 5-bit select input. Its fixed set holds all thirty irreducible polynomials of degree 8 over GF(2). Entry 0 is x^8+x^4+x^3+x+1, so the block can also produce the arithmetic of the standard block cipher.

The product comes from a purely combinational shift-and-add datapath with no storage of any kind. Operand b is multiplied by x seven times, and after each step it is reduced modulo the selected polynomial. Each bit of operand a then decides whether the matching multiple of b is XORed into the result. No lookup memory is used anywhere.

The block is meant to be the arithmetic core of a field inverter or S-box generator. Such a unit raises an element to the power 254 by chaining multiplications and squarings through this block.

Top module: `gf8_prog_mul`

## Requirements
- R1: `prod_o` equals the product of `a_i` and `b_i` as polynomials over GF(2), reduced modulo the polynomial picked by `poly_sel_i`, for every select value 0 to 29.
- R2: Select values 0 to 29 pick thirty distinct polynomials of degree 8, each irreducible over GF(2). The low byte of the picked polynomial can be observed as the product of 0x80 and 0x02.
- R3: Select value 0 picks x^8+x^4+x^3+x+1, whose low byte is 0x1B.
- R4: Select values 30 and 31 give the same results as select value 0.
- R5: If either operand is 0x00, the product is 0x00 under every select value.
- R6: If either operand is 0x01, the product equals the other operand under every select value.
- R7: The product does not depend on operand order: a times b equals b times a.
- R8: With `a_i` = 0x02, the product is `b_i` shifted left by one bit, XORed with the low byte of the picked polynomial whenever bit 7 of `b_i` is set.
- R9: Under every select value 0 to 29, any nonzero element multiplied by its own 254th power, formed by chained products through the block, gives 0x01.
- R10: The output depends only on the current inputs. It settles within the same cycle with no clock, and no state is held between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand; each bit selects one multiple of b |
| b_i | input | 8 | Second operand; multiplied by x at each stage |
| poly_sel_i | input | 5 | Index of the reduction polynomial; 30 and 31 fall back to index 0 |
| prod_o | output | 8 | Reduced product |

## Verification
The assertions check the algebraic identities that hold on every input vector: the zero and one operands, multiplication by x against the picked polynomial, and the fallback of out-of-range select values to 0x1B. Whether the polynomial set is complete, distinct and irreducible, and whether general products are correct, can only be shown by the bench's scenarios. These compare the block against an independent long-division model. They read every polynomial back through the ports and test it by trial division. They also confirm through chained products that each nonzero element raised to the power 255 gives one.

// File: rtl/gf8_mul_pkg.sv
package gf8_mul_pkg;

    // Field width and size of the polynomial set
    localparam int FIELD_W    = 8;
    localparam int POLY_COUNT = 30;
    localparam int SEL_W      = $clog2(POLY_COUNT + 1);
    localparam int STD_IDX    = 0;

    typedef logic [FIELD_W-1:0] gf_byte_t;
    typedef logic [SEL_W-1:0]   poly_idx_t;

    // One stage of the shift-and-add chain
    typedef struct packed {
        gf_byte_t partial;   // running XOR accumulation
        gf_byte_t multiple;  // b * x^i reduced
    } mul_lane_t;

    // Low byte of each irreducible degree-8 polynomial (x^8 term implied).
    // Index 0 is the standard cipher polynomial; the rest ascend.
    function automatic gf_byte_t poly_low_byte(input poly_idx_t idx);
        gf_byte_t r;
        case (idx)
            5'd0:  r = 8'h1B;
            5'd1:  r = 8'h1D;
            5'd2:  r = 8'h2B;
            5'd3:  r = 8'h2D;
            5'd4:  r = 8'h39;
            5'd5:  r = 8'h3F;
            5'd6:  r = 8'h4D;
            5'd7:  r = 8'h5F;
            5'd8:  r = 8'h63;
            5'd9:  r = 8'h65;
            5'd10: r = 8'h69;
            5'd11: r = 8'h71;
            5'd12: r = 8'h77;
            5'd13: r = 8'h7B;
            5'd14: r = 8'h87;
            5'd15: r = 8'h8B;
            5'd16: r = 8'h8D;
            5'd17: r = 8'h9F;
            5'd18: r = 8'hA3;
            5'd19: r = 8'hA9;
            5'd20: r = 8'hB1;
            5'd21: r = 8'hBD;
            5'd22: r = 8'hC3;
            5'd23: r = 8'hCF;
            5'd24: r = 8'hD7;
            5'd25: r = 8'hDD;
            5'd26: r = 8'hE7;
            5'd27: r = 8'hF3;
            5'd28: r = 8'hF5;
            5'd29: r = 8'hF9;
            default: r = 8'h1B;
        endcase
        return r;
    endfunction

    // Multiply by x and reduce with the given low byte
    function automatic gf_byte_t mul_by_x(input gf_byte_t v, input gf_byte_t low);
        gf_byte_t shifted;
        shifted = {v[FIELD_W-2:0], 1'b0};
        return v[FIELD_W-1] ? (shifted ^ low) : shifted;
    endfunction

endpackage

// File: rtl/gf8_poly_select.sv
module gf8_poly_select
    import gf8_mul_pkg::*;
#(
    parameter int COUNT = POLY_COUNT,
    parameter int IW    = SEL_W
) (
    input  logic [IW-1:0]    sel_i,
    output logic [FIELD_W-1:0] low_o
);
    localparam logic [IW-1:0] LIMIT = IW'(COUNT);

    poly_idx_t eff_idx;

    // Out-of-range indices fall back to the standard entry
    always_comb begin
        if (sel_i < LIMIT) begin
            eff_idx = poly_idx_t'(sel_i);
        end else begin
            eff_idx = poly_idx_t'(STD_IDX);
        end
        low_o = poly_low_byte(eff_idx);
    end

endmodule

// File: rtl/gf8_xtime.sv
module gf8_xtime
    import gf8_mul_pkg::*;
(
    input  gf_byte_t val_i,
    input  gf_byte_t low_i,
    output gf_byte_t val_o
);
    always_comb begin
        val_o = mul_by_x(val_i, low_i);
    end
endmodule

// File: rtl/gf8_mul_array.sv
module gf8_mul_array
    import gf8_mul_pkg::*;
#(
    parameter int W = FIELD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] low_i,
    output logic [W-1:0] prod_o
);
    localparam int STAGES = W;

    mul_lane_t lane [STAGES+1];
    gf_byte_t  mult [STAGES];

    assign mult[0] = b_i;

    // Chain of reduced multiples b*x^i
    generate
        for (genvar i = 0; i < STAGES - 1; i++) begin : g_shift
            gf8_xtime u_xt (
                .val_i (mult[i]),
                .low_i (low_i),
                .val_o (mult[i+1])
            );
        end
    endgenerate

    assign lane[0].partial  = '0;
    assign lane[0].multiple = b_i;

    // Conditional XOR accumulation, one stage per bit of a
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_acc
            always_comb begin
                lane[i+1].multiple = mult[i];
                lane[i+1].partial  = a_i[i] ? (lane[i].partial ^ mult[i])
                                            : lane[i].partial;
            end
        end
    endgenerate

    assign prod_o = lane[STAGES].partial;

endmodule

// File: rtl/gf8_prog_mul.sv
module gf8_prog_mul
    import gf8_mul_pkg::*;
(
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic [4:0] poly_sel_i,
    output logic [7:0] prod_o
);
    gf_byte_t poly_byte;

    gf8_poly_select #(
        .COUNT (POLY_COUNT),
        .IW    (SEL_W)
    ) u_sel (
        .sel_i (poly_sel_i),
        .low_o (poly_byte)
    );

    gf8_mul_array #(
        .W (FIELD_W)
    ) u_arr (
        .a_i    (a_i),
        .b_i    (b_i),
        .low_i  (poly_byte),
        .prod_o (prod_o)
    );

endmodule

// File: rtl/gf8_prog_mul_chk.sv
module gf8_prog_mul_chk (
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic [4:0] poly_sel_i,
    input logic [7:0] poly_i,
    input logic [7:0] prod_o
);
    always_comb begin
        // R5
        zero_operand_chk: assert ((a_i != 8'h00 && b_i != 8'h00) || prod_o == 8'h00);
        // R6
        identity_a_chk: assert (a_i != 8'h01 || prod_o == b_i);
        // R6
        identity_b_chk: assert (b_i != 8'h01 || prod_o == a_i);
        // R8
        xtime_chk: assert (a_i != 8'h02 ||
            prod_o == ({b_i[6:0], 1'b0} ^ (b_i[7] ? poly_i : 8'h00)));
        // R4
        fallback_poly_chk: assert (poly_sel_i < 5'd30 || poly_i == 8'h1B);
        // R3
        std_poly_chk: assert (poly_sel_i != 5'd0 || poly_i == 8'h1B);
        // R2
        odd_poly_chk: assert (poly_i[0] == 1'b1);
    end
endmodule

bind gf8_prog_mul gf8_prog_mul_chk u_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .poly_sel_i (poly_sel_i),
    .poly_i     (poly_byte),
    .prod_o     (prod_o)
);

// File: tb/sim_gf8_prog_mul.sv
`timescale 1ns/1ps
module sim_gf8_prog_mul;

    logic       clk;
    logic [7:0] a;
    logic [7:0] b;
    logic [4:0] sel;
    logic [7:0] prod;

    int checks;
    int fails;
    logic done;
    logic [31:0] lfsr;

    gf8_prog_mul u0 (
        .a_i        (a),
        .b_i        (b),
        .poly_sel_i (sel),
        .prod_o     (prod)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Reference: carry-less product, then long division by the full polynomial
    function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y,
                                           input logic [8:0] p);
        logic [14:0] wide;
        wide = '0;
        for (int i = 0; i < 8; i++) begin
            if (x[i]) wide = wide ^ (15'(y) << i);
        end
        for (int k = 14; k >= 8; k--) begin
            if (wide[k]) wide = wide ^ (15'(p) << (k - 8));
        end
        return wide[7:0];
    endfunction

    // Remainder of a polynomial modulo a divisor of lower degree
    function automatic logic [8:0] poly_rem(input logic [8:0] num, input logic [8:0] den);
        logic [8:0] r;
        int dd;
        r  = num;
        dd = 0;
        for (int i = 0; i < 9; i++) if (den[i]) dd = i;
        for (int k = 8; k >= 0; k--) begin
            if (k >= dd && r[k]) r = r ^ (den << (k - dd));
        end
        return r;
    endfunction

    function automatic logic is_irreducible(input logic [8:0] p);
        logic ok;
        ok = 1'b1;
        for (int d = 2; d < 32; d++) begin
            if (poly_rem(p, 9'(d)) == 9'd0) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [4:0] s);
        a   = x;
        b   = y;
        sel = s;
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h (a=%02h b=%02h sel=%0d)",
                     req, got, exp, a, b, sel);
        end
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[7:0] ^ lfsr[23:16];
    endfunction

    logic [7:0] polys [30];

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        lfsr   = 32'hACE1_2357;
        a = '0; b = '0; sel = '0;
        repeat (2) @(negedge clk);

        // Idle state: zero inputs yield zero (R5, R10)
        #1;
        check("R5", prod, 8'h00);

        // R2/R3: read each polynomial back as x^7 * x
        for (int s = 0; s < 30; s++) begin
            apply(8'h80, 8'h02, 5'(s));
            polys[s] = prod;
        end
        check("R3", polys[0], 8'h1B);
        for (int s = 0; s < 30; s++) begin
            checks++;
            if (!is_irreducible({1'b1, polys[s]})) begin
                fails++;
                $display("FAIL R2: sel %0d poly 1%02h reducible, expected irreducible", s, polys[s]);
            end
            for (int t = 0; t < s; t++) begin
                checks++;
                if (polys[t] == polys[s]) begin
                    fails++;
                    $display("FAIL R2: sel %0d poly %02h equals sel %0d, expected distinct", s, polys[s], t);
                end
            end
        end

        // R1: sweep all b against fixed a, and random pairs, for every polynomial
        for (int s = 0; s < 30; s++) begin
            for (int v = 0; v < 256; v++) begin
                apply(8'hC5, 8'(v), 5'(s));
                check("R1", prod, ref_mul(8'hC5, 8'(v), {1'b1, polys[s]}));
            end
            for (int n = 0; n < 120; n++) begin
                logic [7:0] x, y, fwd;
                x = next_rand();
                y = next_rand();
                apply(x, y, 5'(s));
                check("R1", prod, ref_mul(x, y, {1'b1, polys[s]}));
                fwd = prod;
                apply(y, x, 5'(s));
                check("R7", prod, fwd);
            end
        end
        // R1 with the standard polynomial on a known value: 0x57*0x83 = 0xC1
        apply(8'h57, 8'h83, 5'd0);
        check("R1", prod, 8'hC1);

        // R4: out-of-range selects act as index 0
        for (int s = 30; s < 32; s++) begin
            for (int n = 0; n < 64; n++) begin
                logic [7:0] x, y;
                x = next_rand();
                y = next_rand();
                apply(x, y, 5'(s));
                check("R4", prod, ref_mul(x, y, 9'h11B));
            end
        end

        // R5, R6, R8 across all selects and all values
        for (int s = 0; s < 32; s++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] lowp;
                lowp = (s < 30) ? polys[s] : 8'h1B;
                apply(8'h00, 8'(v), 5'(s));  check("R5", prod, 8'h00);
                apply(8'(v), 8'h00, 5'(s));  check("R5", prod, 8'h00);
                apply(8'h01, 8'(v), 5'(s));  check("R6", prod, 8'(v));
                apply(8'(v), 8'h01, 5'(s));  check("R6", prod, 8'(v));
                apply(8'h02, 8'(v), 5'(s));
                check("R8", prod, {v[6:0], 1'b0} ^ (v[7] ? lowp : 8'h00));
            end
        end

        // R9: a^254 by chained products, then a * a^254 == 1
        for (int s = 0; s < 30; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] base, acc;
                base = (k == 0) ? 8'h02 : (k == 1) ? 8'h03 : (k == 2) ? 8'hFF : (next_rand() | 8'h01);
                acc  = 8'h01;
                for (int e = 0; e < 254; e++) begin
                    apply(acc, base, 5'(s));
                    acc = prod;
                end
                apply(base, acc, 5'(s));
                check("R9", prod, 8'h01);
            end
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run not complete, expected completion within 150000 cycles");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule